// File: doc/BRIEF.md
# Register result-latency scoreboard

This block tracks, for every architectural register of an in-order pipeline that issues up to four instructions per cycle, how many cycles remain before the most recent producer's result can be used. Each cycle the issue stage presents a group of instructions. Each slot carries a valid bit, an operation class and a destination register. The block decodes the class into a result latency and loads that register's countdown.

In the same cycle, one candidate instruction is presented with its class and up to two source registers. The block reports per source whether the operand can be consumed now, an overall ready bit, and a stall bit. Readiness depends on how the consumer uses the operand as well as on the producer. Store data and integer branch condition codes accept results from producers issued in the same group. Floating-point add and multiply chains receive results one cycle before other consumers do.

Top module: `reg_latency_sb`

## Requirements
- R1: After reset, including a reset applied while long-latency results are pending, every register reports ready.
- R2: Results of classes 0 (integer ALU), 1 (shift), 2 (compare), 8 (FP move) and 12 (FP compare) are usable one cycle after issue and not in the issue cycle (latency 1).
- R3: Class 3 (load) has latency 2 and class 4 (sign-extending load) has latency 3.
- R4: Class 7 (integer conditional move) and class 9 (FP conditional move) have latency 2.
- R5: Classes 10 (FP add/sub) and 11 (FP multiply) have latency 4 for most consumers and latency 3 when the candidate's class is 10 or 11.
- R6: Class 13 (single divide/sqrt) has latency 13, or 12 for a class 10/11 candidate; class 14 (double divide/sqrt) has latency 23, or 22 for a class 10/11 candidate.
- R7: For a candidate of class 5 (store), source 1 is the data operand. It is ready at any time, including the producer's own issue cycle, when the register's latest producer is of class 0, 1, 2, 8, 9, 10 or 11. Data from any other producer class, and store source 0 (address), follow the normal latency.
- R8: For a candidate of class 6 (branch), source 0 is the condition code. It is ready in the issue cycle of a class 2 producer in the same group. A class 12 producer in the same group leaves it not ready.
- R9: A later writer of a register replaces the pending countdown, whatever the earlier latency was. Within one group, the writer in the highest slot index takes effect.
- R10: Slots with valid low, and slots of class 5 (store), 6 (branch) or 15 (no result), write no register.
- R11: A source whose use bit is low reads as ready. The overall ready bit is the AND of both source ready bits. Stall equals candidate valid AND NOT ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | ISSUE_W | Per-slot issue valid |
| issueClass | input | ISSUE_W x 4 | Per-slot operation class |
| issueDest | input | ISSUE_W x REG_W | Per-slot destination register |
| candValid | input | 1 | Candidate instruction present |
| candClass | input | 4 | Candidate operation class |
| candSrc0 | input | REG_W | Candidate source 0 register |
| candSrc0Used | input | 1 | Source 0 is read |
| candSrc1 | input | REG_W | Candidate source 1 register |
| candSrc1Used | input | 1 | Source 1 is read |
| srcReady | output | 2 | Per-source ready, bit 1 for source 1 |
| candReady | output | 1 | All used sources ready |
| candStall | output | 1 | Valid candidate that must wait |

## Verification
A same-group bypass and a running countdown can both apply to the same register in the same cycle. One case is a store whose data register still has a long countdown while the group also rewrites it. Another is a group with two writers of one register. The bench provokes these with groups that put a divide and a simple ALU op on one destination, with the candidate presented in the issue cycle. It checks that only the highest-slot producer decides both the bypass and the next cycle's readiness. It also pairs a compare with an FP compare in one group under a branch candidate, and judges that only the integer compare opens the zero-cycle path.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [3:0] {
    CLS_ALU    = 4'd0,
    CLS_SHIFT  = 4'd1,
    CLS_CMP    = 4'd2,
    CLS_LOAD   = 4'd3,
    CLS_SLOAD  = 4'd4,
    CLS_STORE  = 4'd5,
    CLS_BRANCH = 4'd6,
    CLS_ICMOV  = 4'd7,
    CLS_FMOV   = 4'd8,
    CLS_FCMOV  = 4'd9,
    CLS_FADD   = 4'd10,
    CLS_FMUL   = 4'd11,
    CLS_FCMP   = 4'd12,
    CLS_FDIVS  = 4'd13,
    CLS_FDIVD  = 4'd14,
    CLS_NONE   = 4'd15
  } opClass_e;

  typedef enum logic [1:0] {
    ROLE_PLAIN   = 2'd0,
    ROLE_STDATA  = 2'd1,
    ROLE_CC      = 2'd2,
    ROLE_FPCHAIN = 2'd3
  } srcRole_e;

  // strobes from the issue decoder to the countdown file
  typedef struct packed {
    logic we;
    logic early;
    logic dataFwd;
  } wrStrobe_t;

  function automatic int classLatency(opClass_e c);
    case (c)
      CLS_ALU, CLS_SHIFT, CLS_CMP, CLS_FMOV, CLS_FCMP: return 1;
      CLS_LOAD, CLS_ICMOV, CLS_FCMOV:                  return 2;
      CLS_SLOAD:                                       return 3;
      CLS_FADD, CLS_FMUL:                              return 4;
      CLS_FDIVS:                                       return 13;
      CLS_FDIVD:                                       return 23;
      default:                                         return 0;
    endcase
  endfunction

  function automatic logic writesReg(opClass_e c);
    return !(c inside {CLS_STORE, CLS_BRANCH, CLS_NONE});
  endfunction

  function automatic logic feedsStoreData(opClass_e c);
    return c inside {CLS_ALU, CLS_SHIFT, CLS_CMP, CLS_FMOV, CLS_FCMOV,
                     CLS_FADD, CLS_FMUL};
  endfunction

  function automatic logic fpEarlyProducer(opClass_e c);
    return c inside {CLS_FADD, CLS_FMUL, CLS_FDIVS, CLS_FDIVD};
  endfunction

  function automatic srcRole_e roleOf(opClass_e c, int idx);
    case (c)
      CLS_STORE:          return (idx == 1) ? ROLE_STDATA : ROLE_PLAIN;
      CLS_BRANCH:         return (idx == 0) ? ROLE_CC : ROLE_PLAIN;
      CLS_FADD, CLS_FMUL: return ROLE_FPCHAIN;
      default:            return ROLE_PLAIN;
    endcase
  endfunction

endpackage

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
  import sb_pkg::*;
#(
  parameter int ISSUE_W = 4,
  parameter int REG_W   = 5,
  parameter int CNT_W   = 5
) (
  input  logic [ISSUE_W-1:0]            issueValid,
  input  logic [ISSUE_W-1:0][3:0]       issueClass,
  input  logic [ISSUE_W-1:0][REG_W-1:0] issueDest,
  output wrStrobe_t [ISSUE_W-1:0]       wrStrb,
  output logic [ISSUE_W-1:0][REG_W-1:0] wrDest,
  output logic [ISSUE_W-1:0][CNT_W-1:0] wrLoad
);

  for (genvar s = 0; s < ISSUE_W; s++) begin : gSlot
    opClass_e slotCls;
    int       slotLat;

    always_comb begin
      slotCls = opClass_e'(issueClass[s]);
      slotLat = classLatency(slotCls);
      wrStrb[s].we      = issueValid[s] && writesReg(slotCls);
      wrStrb[s].early   = fpEarlyProducer(slotCls);
      wrStrb[s].dataFwd = feedsStoreData(slotCls);
      wrDest[s]         = issueDest[s];
      // countdown holds cycles left minus one, so zero means usable
      wrLoad[s]         = (slotLat > 0) ? CNT_W'(slotLat - 1) : '0;
    end
  end

endmodule

// File: rtl/sb_cnt_file.sv
module sb_cnt_file
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int ISSUE_W  = 4,
  parameter int REG_W    = 5,
  parameter int CNT_W    = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  wrStrobe_t [ISSUE_W-1:0]       wrStrb,
  input  logic [ISSUE_W-1:0][REG_W-1:0] wrDest,
  input  logic [ISSUE_W-1:0][CNT_W-1:0] wrLoad,
  output logic [NUM_REGS-1:0][CNT_W-1:0] regCnt,
  output logic [NUM_REGS-1:0]           regEarly,
  output logic [NUM_REGS-1:0]           regFwd
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : gReg
    logic             hit;
    logic [CNT_W-1:0] selLoad;
    logic             selEarly;
    logic             selFwd;
    logic [CNT_W-1:0] cntQ;
    logic             earlyQ;
    logic             fwdQ;

    // ascending scan: the highest slot that names this register wins
    always_comb begin
      hit      = 1'b0;
      selLoad  = '0;
      selEarly = 1'b0;
      selFwd   = 1'b0;
      for (int s = 0; s < ISSUE_W; s++) begin
        if (wrStrb[s].we && (wrDest[s] == REG_W'(r))) begin
          hit      = 1'b1;
          selLoad  = wrLoad[s];
          selEarly = wrStrb[s].early;
          selFwd   = wrStrb[s].dataFwd;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ   <= '0;
        earlyQ <= 1'b0;
        fwdQ   <= 1'b0;
      end else if (hit) begin
        cntQ   <= selLoad;
        earlyQ <= selEarly;
        fwdQ   <= selFwd;
      end else if (cntQ != '0) begin
        cntQ   <= cntQ - CNT_W'(1);
      end
    end

    assign regCnt[r]   = cntQ;
    assign regEarly[r] = earlyQ;
    assign regFwd[r]   = fwdQ;

    // R9: a new writer replaces whatever countdown was pending
    assert_reload_R9: assert property (@(posedge clk) disable iff (!rstN)
      hit |=> (cntQ == $past(selLoad)));

    // R3: a countdown at one with no new writer is usable next cycle
    assert_drain_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!hit && cntQ == CNT_W'(1)) |=> (cntQ == '0));
  end

endmodule

// File: rtl/sb_ready_eval.sv
module sb_ready_eval
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int ISSUE_W  = 4,
  parameter int REG_W    = 5,
  parameter int CNT_W    = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ISSUE_W-1:0]             slotWe,
  input  logic [ISSUE_W-1:0][3:0]        issueClass,
  input  logic [ISSUE_W-1:0][REG_W-1:0]  wrDest,
  input  logic [NUM_REGS-1:0][CNT_W-1:0] regCnt,
  input  logic [NUM_REGS-1:0]            regEarly,
  input  logic [NUM_REGS-1:0]            regFwd,
  input  logic                           candValid,
  input  logic [3:0]                     candClass,
  input  logic [1:0][REG_W-1:0]          candSrc,
  input  logic [1:0]                     candUsed,
  output logic [1:0]                     srcReady,
  output logic                           candReady,
  output logic                           candStall
);

  opClass_e candCls;
  assign candCls = opClass_e'(candClass);

  for (genvar i = 0; i < 2; i++) begin : gSrc
    srcRole_e         role;
    logic             sameHit;
    opClass_e         sameCls;
    logic [CNT_W-1:0] cnt;
    logic             rdy;

    always_comb begin
      role    = roleOf(candCls, i);
      sameHit = 1'b0;
      sameCls = CLS_NONE;
      for (int s = 0; s < ISSUE_W; s++) begin
        if (slotWe[s] && (wrDest[s] == candSrc[i])) begin
          sameHit = 1'b1;
          sameCls = opClass_e'(issueClass[s]);
        end
      end
      cnt = regCnt[candSrc[i]];
      if (!candUsed[i]) begin
        rdy = 1'b1;
      end else if (sameHit) begin
        rdy = ((role == ROLE_STDATA) && feedsStoreData(sameCls)) ||
              ((role == ROLE_CC) && (sameCls == CLS_CMP));
      end else begin
        rdy = (cnt == '0) ||
              ((role == ROLE_STDATA) && regFwd[candSrc[i]]) ||
              ((role == ROLE_FPCHAIN) && regEarly[candSrc[i]] &&
               (cnt <= CNT_W'(1)));
      end
    end

    assign srcReady[i] = rdy;

    // R7: a divide issued in this group never feeds any operand at once
    assert_div_no_same_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
      (candUsed[i] && sameHit && (sameCls inside {CLS_FDIVS, CLS_FDIVD})) |-> !srcReady[i]);
  end

  assign candReady = &srcReady;
  assign candStall = candValid && !candReady;

  // R11: stall is raised only for a candidate that is present
  assert_stall_needs_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    candStall |-> candValid);

  // R11: a candidate with no sources in use never stalls
  assert_no_src_no_stall_R11: assert property (@(posedge clk) disable iff (!rstN)
    (candUsed == 2'b00) |-> !candStall);

endmodule

// File: rtl/reg_latency_sb.sv
module reg_latency_sb
  import sb_pkg::*;
#(
  parameter int  ISSUE_W  = 4,
  parameter int  NUM_REGS = 32,
  parameter int  CNT_W    = 5,
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ISSUE_W-1:0]            issueValid,
  input  logic [ISSUE_W-1:0][3:0]       issueClass,
  input  logic [ISSUE_W-1:0][REG_W-1:0] issueDest,
  input  logic                          candValid,
  input  logic [3:0]                    candClass,
  input  logic [REG_W-1:0]              candSrc0,
  input  logic                          candSrc0Used,
  input  logic [REG_W-1:0]              candSrc1,
  input  logic                          candSrc1Used,
  output logic [1:0]                    srcReady,
  output logic                          candReady,
  output logic                          candStall
);

  wrStrobe_t [ISSUE_W-1:0]        wrStrb;
  logic [ISSUE_W-1:0][REG_W-1:0]  wrDest;
  logic [ISSUE_W-1:0][CNT_W-1:0]  wrLoad;
  logic [ISSUE_W-1:0]             slotWe;
  logic [NUM_REGS-1:0][CNT_W-1:0] regCnt;
  logic [NUM_REGS-1:0]            regEarly;
  logic [NUM_REGS-1:0]            regFwd;

  for (genvar s = 0; s < ISSUE_W; s++) begin : gWe
    assign slotWe[s] = wrStrb[s].we;
  end

  sb_issue_ctrl #(
    .ISSUE_W(ISSUE_W), .REG_W(REG_W), .CNT_W(CNT_W)
  ) uCtrl (
    .issueValid(issueValid),
    .issueClass(issueClass),
    .issueDest (issueDest),
    .wrStrb    (wrStrb),
    .wrDest    (wrDest),
    .wrLoad    (wrLoad)
  );

  sb_cnt_file #(
    .NUM_REGS(NUM_REGS), .ISSUE_W(ISSUE_W), .REG_W(REG_W), .CNT_W(CNT_W)
  ) uCnt (
    .clk     (clk),
    .rstN    (rstN),
    .wrStrb  (wrStrb),
    .wrDest  (wrDest),
    .wrLoad  (wrLoad),
    .regCnt  (regCnt),
    .regEarly(regEarly),
    .regFwd  (regFwd)
  );

  sb_ready_eval #(
    .NUM_REGS(NUM_REGS), .ISSUE_W(ISSUE_W), .REG_W(REG_W), .CNT_W(CNT_W)
  ) uReady (
    .clk       (clk),
    .rstN      (rstN),
    .slotWe    (slotWe),
    .issueClass(issueClass),
    .wrDest    (wrDest),
    .regCnt    (regCnt),
    .regEarly  (regEarly),
    .regFwd    (regFwd),
    .candValid (candValid),
    .candClass (candClass),
    .candSrc   ({candSrc1, candSrc0}),
    .candUsed  ({candSrc1Used, candSrc0Used}),
    .srcReady  (srcReady),
    .candReady (candReady),
    .candStall (candStall)
  );

endmodule

// File: tb/test_reg_latency_sb.sv
`timescale 1ns/10ps
module test_reg_latency_sb;

  localparam logic [3:0] A  = 4'd0;   // integer ALU
  localparam logic [3:0] SH = 4'd1;
  localparam logic [3:0] CM = 4'd2;
  localparam logic [3:0] LD = 4'd3;
  localparam logic [3:0] SL = 4'd4;
  localparam logic [3:0] ST = 4'd5;
  localparam logic [3:0] BR = 4'd6;
  localparam logic [3:0] IC = 4'd7;
  localparam logic [3:0] FM = 4'd8;
  localparam logic [3:0] FC = 4'd9;
  localparam logic [3:0] FA = 4'd10;
  localparam logic [3:0] FU = 4'd11;
  localparam logic [3:0] FP = 4'd12;
  localparam logic [3:0] DS = 4'd13;
  localparam logic [3:0] DD = 4'd14;
  localparam logic [3:0] N  = 4'd15;

  typedef struct packed {
    logic [3:0]      iv;
    logic [3:0][3:0] ic;
    logic [3:0][4:0] id;
    logic            cv;
    logic [3:0]      cc;
    logic [4:0]      s0;
    logic [4:0]      s1;
    logic [1:0]      used;
    logic [1:0]      exp;
    logic [3:0]      req;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VECS [NV] = '{
    '{4'b0001, {N,N,N,A},   {5'd0,5'd0,5'd0,5'd1},    1'b1, A,  5'd1,  5'd0,  2'b01, 2'b10, 4'd2},  // R2 same cycle
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, A,  5'd1,  5'd0,  2'b01, 2'b11, 4'd2},  // R2
    '{4'b0010, {N,N,LD,N},  {5'd0,5'd0,5'd2,5'd0},    1'b1, A,  5'd2,  5'd0,  2'b01, 2'b10, 4'd3},  // R3 load
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, A,  5'd2,  5'd0,  2'b01, 2'b10, 4'd3},  // R3
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, A,  5'd2,  5'd0,  2'b01, 2'b11, 4'd3},  // R3
    '{4'b0001, {N,N,N,SL},  {5'd0,5'd0,5'd0,5'd3},    1'b1, A,  5'd3,  5'd0,  2'b01, 2'b10, 4'd3},  // R3 sload
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, A,  5'd3,  5'd0,  2'b01, 2'b10, 4'd3},  // R3
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, A,  5'd3,  5'd0,  2'b01, 2'b10, 4'd3},  // R3
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, A,  5'd3,  5'd0,  2'b01, 2'b11, 4'd3},  // R3
    '{4'b0011, {N,N,FU,FA}, {5'd0,5'd0,5'd6,5'd4},    1'b1, FA, 5'd4,  5'd6,  2'b11, 2'b00, 4'd5},  // R5
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, ST, 5'd5,  5'd4,  2'b11, 2'b11, 4'd7},  // R7 fadd data
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, FU, 5'd4,  5'd6,  2'b11, 2'b00, 4'd5},  // R5
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, A,  5'd4,  5'd0,  2'b01, 2'b10, 4'd5},  // R5 general
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, A,  5'd6,  5'd0,  2'b01, 2'b11, 4'd5},  // R5
    '{4'b0001, {N,N,N,FU},  {5'd0,5'd0,5'd0,5'd7},    1'b1, FA, 5'd7,  5'd0,  2'b01, 2'b10, 4'd5},  // R5
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, FA, 5'd7,  5'd0,  2'b01, 2'b10, 4'd5},  // R5
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, FA, 5'd7,  5'd0,  2'b01, 2'b10, 4'd5},  // R5
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, FA, 5'd7,  5'd0,  2'b01, 2'b11, 4'd5},  // R5 early
    '{4'b1001, {FC,N,N,IC}, {5'd9,5'd0,5'd0,5'd8},    1'b1, ST, 5'd8,  5'd9,  2'b11, 2'b10, 4'd4},  // R4 R7
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, A,  5'd8,  5'd9,  2'b11, 2'b00, 4'd4},  // R4
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, A,  5'd8,  5'd9,  2'b11, 2'b11, 4'd4},  // R4
    '{4'b0110, {N,FP,CM,N}, {5'd0,5'd11,5'd10,5'd0},  1'b1, BR, 5'd10, 5'd0,  2'b01, 2'b11, 4'd8},  // R8 cmp
    '{4'b0001, {N,N,N,FP},  {5'd0,5'd0,5'd0,5'd11},   1'b1, BR, 5'd11, 5'd0,  2'b01, 2'b10, 4'd8},  // R8 fcmp
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, BR, 5'd11, 5'd0,  2'b01, 2'b11, 4'd8},  // R8
    '{4'b0011, {N,N,FM,SH}, {5'd0,5'd0,5'd13,5'd12},  1'b1, ST, 5'd12, 5'd13, 2'b11, 2'b10, 4'd7},  // R7 addr/data
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, A,  5'd12, 5'd13, 2'b11, 2'b11, 4'd2},  // R2
    '{4'b0001, {N,N,N,LD},  {5'd0,5'd0,5'd0,5'd14},   1'b1, ST, 5'd1,  5'd14, 2'b11, 2'b01, 4'd7},  // R7 load data
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, ST, 5'd1,  5'd14, 2'b11, 2'b01, 4'd7},  // R7
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, ST, 5'd1,  5'd14, 2'b11, 2'b11, 4'd7},  // R7
    '{4'b1001, {A,N,N,DD},  {5'd15,5'd0,5'd0,5'd15},  1'b1, ST, 5'd1,  5'd15, 2'b11, 2'b11, 4'd9},  // R9 slot order
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, A,  5'd15, 5'd0,  2'b01, 2'b11, 4'd9},  // R9
    '{4'b1111, {LD,N,BR,ST},{5'd19,5'd18,5'd17,5'd16},1'b1, A,  5'd16, 5'd17, 2'b11, 2'b11, 4'd10}, // R10
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, A,  5'd18, 5'd19, 2'b11, 2'b01, 4'd10}, // R10
    '{4'b0001, {N,N,N,DS},  {5'd0,5'd0,5'd0,5'd20},   1'b0, A,  5'd20, 5'd0,  2'b01, 2'b10, 4'd11}, // R11 no stall
    '{4'b0001, {N,N,N,A},   {5'd0,5'd0,5'd0,5'd20},   1'b1, A,  5'd20, 5'd0,  2'b01, 2'b10, 4'd9},  // R9
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, A,  5'd20, 5'd0,  2'b01, 2'b11, 4'd9},  // R9 overwrite
    '{4'b0000, {N,N,N,LD},  {5'd0,5'd0,5'd0,5'd21},   1'b1, A,  5'd21, 5'd0,  2'b01, 2'b11, 4'd10}, // R10 invalid slot
    '{4'b0000, {N,N,N,N},   {5'd0,5'd0,5'd0,5'd0},    1'b1, A,  5'd21, 5'd0,  2'b01, 2'b11, 4'd10}, // R10
    '{4'b0001, {N,N,N,LD},  {5'd0,5'd0,5'd0,5'd22},   1'b1, A,  5'd22, 5'd22, 2'b00, 2'b11, 4'd11}  // R11 unused
  };

  logic            clk = 1'b0;
  logic            rstN;
  logic [3:0]      issueValid;
  logic [3:0][3:0] issueClass;
  logic [3:0][4:0] issueDest;
  logic            candValid;
  logic [3:0]      candClass;
  logic [4:0]      candSrc0;
  logic            candSrc0Used;
  logic [4:0]      candSrc1;
  logic            candSrc1Used;
  logic [1:0]      srcReady;
  logic            candReady;
  logic            candStall;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  reg_latency_sb i_reg_latency_sb (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueClass(issueClass), .issueDest(issueDest),
    .candValid(candValid), .candClass(candClass),
    .candSrc0(candSrc0), .candSrc0Used(candSrc0Used),
    .candSrc1(candSrc1), .candSrc1Used(candSrc1Used),
    .srcReady(srcReady), .candReady(candReady), .candStall(candStall)
  );

  task automatic clearIssue();
    issueValid = '0;
    issueClass = {N, N, N, N};
    issueDest  = '0;
  endtask

  task automatic setCand(input logic cv, input logic [3:0] cls,
                         input logic [4:0] s0, input logic [4:0] s1,
                         input logic [1:0] used);
    candValid    = cv;
    candClass    = cls;
    candSrc0     = s0;
    candSrc1     = s1;
    candSrc0Used = used[0];
    candSrc1Used = used[1];
  endtask

  // expected ready/stall follow R11 from the per-source expectation
  task automatic chk(input int req, input int tag, input logic [1:0] exp, input logic cv);
    logic expRdy;
    logic expStall;
    expRdy   = &exp;
    expStall = cv && !expRdy;
    total++;
    if (srcReady !== exp || candReady !== expRdy || candStall !== expStall) begin
      bad++;
      $display("FAIL R%0d step %0d: srcReady=%b ready=%b stall=%b expected srcReady=%b ready=%b stall=%b",
               req, tag, srcReady, candReady, candStall, exp, expRdy, expStall);
    end
  endtask

  task automatic divTest(input logic [3:0] cls, input logic [4:0] dst, input int lat);
    @(negedge clk);
    issueValid = 4'b0001;
    issueClass = {N, N, N, cls};
    issueDest  = {5'd0, 5'd0, 5'd0, dst};
    setCand(1'b1, FA, dst, 5'd0, 2'b01);
    #0.4 chk(6, 0, 2'b10, 1'b1);                    // R6 issue cycle
    setCand(1'b1, ST, 5'd0, dst, 2'b10);
    #0.4 chk(7, 0, 2'b01, 1'b1);                    // R7 no bypass from divide
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      clearIssue();
      setCand(1'b1, FA, dst, 5'd0, 2'b01);
      #0.4 chk(6, k, {1'b1, (k >= lat - 1)}, 1'b1); // R6 FP chain consumer
      setCand(1'b1, A, dst, 5'd0, 2'b01);
      #0.4 chk(6, k, {1'b1, (k >= lat)}, 1'b1);     // R6 other consumer
      setCand(1'b1, ST, 5'd0, dst, 2'b10);
      #0.4 chk(7, k, {(k >= lat), 1'b1}, 1'b1);     // R7 store data waits
    end
  endtask

  initial begin
    rstN = 1'b0;
    clearIssue();
    setCand(1'b0, A, 5'd0, 5'd0, 2'b00);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: every register ready out of reset
    for (int r = 0; r < 32; r++) begin
      @(negedge clk);
      setCand(1'b1, A, 5'(r), 5'(31 - r), 2'b11);
      #1 chk(1, r, 2'b11, 1'b1);
    end

    // table walk: R2 R3 R4 R5 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      issueValid = VECS[i].iv;
      issueClass = VECS[i].ic;
      issueDest  = VECS[i].id;
      setCand(VECS[i].cv, VECS[i].cc, VECS[i].s0, VECS[i].s1, VECS[i].used);
      #1 chk(int'(VECS[i].req), i, VECS[i].exp, VECS[i].cv);
    end
    @(negedge clk);
    clearIssue();

    // R6: divide latencies, single then double
    divTest(DS, 5'd23, 13);
    divTest(DD, 5'd24, 23);

    // R1: reset while a double divide is pending
    @(negedge clk);
    issueValid = 4'b0001;
    issueClass = {N, N, N, DD};
    issueDest  = {5'd0, 5'd0, 5'd0, 5'd25};
    @(negedge clk);
    clearIssue();
    setCand(1'b1, A, 5'd25, 5'd0, 2'b01);
    #0.4 chk(6, 100, 2'b10, 1'b1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #0.4 chk(1, 101, 2'b11, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule